// File: doc/BRIEF.md
# Four-Channel Motor PWM Controller

This peripheral sits on a 32-bit AXI4-Lite slave port and produces the drive signals for four brushed-motor driver channels. Software programs one shared PWM period, a separate duty value per channel, and a packed control word with an enable, a direction and a brake bit for each channel. Each channel presents a PWM output, a direction output and a brake output to its motor driver.

On a differential-drive vehicle, channels 0 and 1 are the left wheels and channels 2 and 3 are the right wheels. Steering comes from giving the two sides unequal duty. Setting every duty to zero lets the motors coast to a halt. Setting brake bits holds the motors actively. All four channels run from one free-running counter, so their pulses stay phase-aligned. Period and duty changes are picked up only at the counter wrap, so a pulse is never cut short or stretched partway through.

Top module: `motor_pwm4`

## Requirements
- R1: After reset every register reads zero and all PWM, direction and brake outputs are low.
- R2: Registers are word-aligned at byte offsets 0x00 (control), 0x04 (period), and 0x08, 0x0C, 0x10, 0x14 (duty of channels 0 to 3). Each register reads back its last written 32-bit value, and only the bytes whose write strobe bit is set are updated.
- R3: A read from an offset outside the map returns zero. A write to such an offset changes no register. Both get an OKAY (0) response.
- R4: With period P > 0 and duty D, an enabled, unbraked channel is high for min(D, P) cycles out of every P. A duty greater than or equal to the period holds the output high continuously.
- R5: A period of zero holds every PWM output low.
- R6: Control bit 8+i is channel i's brake. While it is set, brake output i is high and PWM output i is low, whatever the enable bit and duty are.
- R7: Control bit i is channel i's enable. While it is clear and the brake bit is clear, PWM output i and brake output i are both low (coast).
- R8: Direction output i follows control bit 4+i.
- R9: A duty or period written in the middle of a PWM cycle takes effect only at the next counter wrap.
- R10: Write and read responses stay valid, with stable data, until the master accepts them. Every response code is OKAY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_awaddr | input | 8 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 8 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| pwm_o | output | 4 | PWM output per channel |
| dir_o | output | 4 | Direction output per channel |
| brake_o | output | 4 | Brake output per channel |

## Verification
The hardest case to reach from the ports is the deferred update. Nothing at the interface shows where the shared counter is within its cycle. The stimulus sets up a second channel with a duty of one, so that its single high cycle marks the wrap. The bench then writes a new duty partway through a cycle and checks that the target channel stays low until the marker pulse and goes high on that same cycle. Randomised period, duty and control patterns are scored by counting high cycles over one full period, and this count does not depend on the counter's phase.

// File: rtl/motor_pwm4.sv
module motor_pwm4 #(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [NCH-1:0]    pwm_o,
  output logic [NCH-1:0]    dir_o,
  output logic [NCH-1:0]    brake_o
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int NREG  = NCH + 2;

  logic [31:0] ctrl_q, per_q, per_act, cnt;
  logic [31:0] duty_q   [NCH];
  logic [31:0] duty_act [NCH];
  logic [IDX_W-1:0] widx, ridx;
  logic wr_go, wrap;
  logic [31:0] rd_word;

  wire unused_lsbs = ^{s_awaddr[1:0], s_araddr[1:0]};

  assign widx = s_awaddr[ADDR_W-1:2];
  assign ridx = s_araddr[ADDR_W-1:2];

  assign wr_go     = s_awvalid & s_wvalid & ~s_bvalid;
  assign s_awready = wr_go;
  assign s_wready  = wr_go;
  assign s_bresp   = 2'b00;
  assign s_rresp   = 2'b00;
  assign s_arready = ~s_rvalid;

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] strb);
    for (int b = 0; b < 4; b++)
      merge[8*b +: 8] = strb[b] ? nw[8*b +: 8] : old[8*b +: 8];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      per_q    <= '0;
      s_bvalid <= 1'b0;
      for (int k = 0; k < NCH; k++) duty_q[k] <= '0;
    end else begin
      if (s_bvalid && s_bready) s_bvalid <= 1'b0;
      if (wr_go) begin
        s_bvalid <= 1'b1;
        if (widx == IDX_W'(0)) ctrl_q <= merge(ctrl_q, s_wdata, s_wstrb);
        if (widx == IDX_W'(1)) per_q  <= merge(per_q, s_wdata, s_wstrb);
        for (int k = 0; k < NCH; k++)
          if (widx == IDX_W'(k + 2)) duty_q[k] <= merge(duty_q[k], s_wdata, s_wstrb);
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (ridx == IDX_W'(0)) rd_word = ctrl_q;
    if (ridx == IDX_W'(1)) rd_word = per_q;
    for (int k = 0; k < NCH; k++)
      if (ridx == IDX_W'(k + 2)) rd_word = duty_q[k];
    if (int'(ridx) >= NREG) rd_word = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_rvalid <= 1'b0;
      s_rdata  <= '0;
    end else if (s_rvalid) begin
      if (s_rready) s_rvalid <= 1'b0;
    end else if (s_arvalid) begin
      s_rvalid <= 1'b1;
      s_rdata  <= rd_word;
    end
  end

  assign wrap = (per_act == '0) || (cnt >= per_act - 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      per_act <= '0;
      for (int k = 0; k < NCH; k++) duty_act[k] <= '0;
    end else if (wrap) begin
      cnt     <= '0;
      per_act <= per_q;
      for (int k = 0; k < NCH; k++) duty_act[k] <= duty_q[k];
    end else begin
      cnt <= cnt + 32'd1;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic on_w;
    assign on_w       = (per_act != '0) && (cnt < duty_act[i]);
    assign pwm_o[i]   = ctrl_q[i] & ~ctrl_q[2*NCH + i] & on_w;
    assign dir_o[i]   = ctrl_q[NCH + i];
    assign brake_o[i] = ctrl_q[2*NCH + i];
  end
endmodule

module motor_pwm4_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bvalid,
  input logic           bready,
  input logic [1:0]     bresp,
  input logic           rvalid,
  input logic           rready,
  input logic [31:0]    rdata,
  input logic [1:0]     rresp,
  input logic [NCH-1:0] pwm,
  input logic [NCH-1:0] brake,
  input logic [NCH-1:0] en,
  input logic [31:0]    per_live
);
  // R10
  b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid);
  // R10
  r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rdata));
  // R3
  resp_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid |-> bresp == 2'b00) and (rvalid |-> rresp == 2'b00));
  // R6
  brake_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pwm & brake) == 0);
  // R7
  coast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pwm & ~en) == 0);
  // R5
  zero_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_live == 32'd0 |-> pwm == '0);
endmodule

bind motor_pwm4 motor_pwm4_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
  .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata), .rresp(s_rresp),
  .pwm(pwm_o), .brake(brake_o), .en(ctrl_q[NCH-1:0]), .per_live(per_act)
);

// File: tb/motor_pwm4_test.sv
`timescale 1ns/1ps
module motor_pwm4_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] awaddr = '0, araddr = '0;
  logic awvalid = 0, wvalid = 0, bready = 1, arvalid = 0, rready = 1;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;
  logic [3:0] pwm_o, dir_o, brake_o;
  int checks = 0, errors = 0;
  bit done = 0;
  int hi [4];

  always #2.5 clk = ~clk;

  motor_pwm4 uut (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .pwm_o(pwm_o), .dir_o(dir_o), .brake_o(brake_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s = 4'hF);
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    chk("R10 bvalid", {31'd0, bvalid}, 1);
    chk("R10 bresp", {30'd0, bresp}, 0);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    araddr = a; arvalid = 1;
    @(negedge clk);
    arvalid = 0;
    chk("R10 rvalid", {31'd0, rvalid}, 1);
    chk("R3 rresp", {30'd0, rresp}, 0);
    d = rdata;
  endtask

  task automatic measure(input int per);
    for (int c = 0; c < 4; c++) hi[c] = 0;
    for (int n = 0; n < per; n++) begin
      @(negedge clk);
      for (int c = 0; c < 4; c++) hi[c] += int'(pwm_o[c]);
    end
  endtask

  function automatic int exp_hi(input logic [11:0] ctl, input int c, input int per, input int duty);
    if (ctl[8+c] || !ctl[c] || per == 0) return 0;
    return (duty < per) ? duty : per;
  endfunction

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int duty [4];
    void'($urandom(32'h5A17));
    wait_cycles(3);
    // R1 reset state
    chk("R1 pwm", {28'd0, pwm_o}, 0);
    chk("R1 dir", {28'd0, dir_o}, 0);
    chk("R1 brake", {28'd0, brake_o}, 0);
    rst_n = 1;
    for (int r = 0; r < 6; r++) begin
      rd(8'(4*r), v);
      chk("R1 reg zero", v, 0);
    end

    // R2 readback and strobes
    wr(8'h08, 32'hA5A5_1234); rd(8'h08, v); chk("R2 duty0", v, 32'hA5A5_1234);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h14, 32'h1234_5678, 4'b0101); rd(8'h14, v); chk("R2 strobe", v, 32'hFF34_FF78);
    wr(8'h00, 32'hDEAD_B000); rd(8'h00, v); chk("R2 ctrl", v, 32'hDEAD_B000);

    // R3 unmapped
    wr(8'h18, 32'hFFFF_FFFF); wr(8'h3C, 32'hFFFF_FFFF);
    rd(8'h18, v); chk("R3 read 0x18", v, 0);
    rd(8'hFC, v); chk("R3 read 0xFC", v, 0);
    rd(8'h00, v); chk("R3 ctrl intact", v, 32'hDEAD_B000);
    rd(8'h04, v); chk("R3 period intact", v, 0);
    rd(8'h14, v); chk("R3 duty3 intact", v, 32'hFF34_FF78);

    // R10 write response held while bready low
    bready = 0;
    wr(8'h04, 32'd0);
    wait_cycles(3);
    chk("R10 bvalid held", {31'd0, bvalid}, 1);
    bready = 1;
    wait_cycles(1);
    chk("R10 bvalid cleared", {31'd0, bvalid}, 0);

    // R5 period zero: enabled channels with duty stay low
    wr(8'h00, 32'h00F);
    for (int c = 0; c < 4; c++) wr(8'(8 + 4*c), 32'd5);
    wait_cycles(5); measure(40);
    for (int c = 0; c < 4; c++) chk("R5 zero period", hi[c], 0);

    // R4 full duty, R8 direction, R6 brake, R7 coast
    wr(8'h00, 32'h2A3);
    wr(8'h04, 32'd8);
    wr(8'h08, 32'd8); wr(8'h0C, 32'd200); wr(8'h10, 32'd3); wr(8'h14, 32'd3);
    wait_cycles(30); measure(8);
    chk("R4 duty=period", hi[0], 8);
    chk("R6 braked channel", hi[1], 0);
    chk("R7 disabled channel", hi[2], 0);
    chk("R7 disabled brake", {31'd0, brake_o[2]}, 0);
    chk("R6 brake out", {28'd0, brake_o}, 4'b0010);
    chk("R8 dir", {28'd0, dir_o}, 4'b1010);
    chk("R7 ch3 coast", hi[3], 0);

    // R9 deferred duty: channel 1 duty 1 marks the wrap
    wr(8'h00, 32'h003);
    wr(8'h04, 32'd20);
    wr(8'h08, 32'd0); wr(8'h0C, 32'd1);
    wait_cycles(50);
    for (int n = 0; n < 40 && !pwm_o[1]; n++) @(negedge clk);
    wait_cycles(2);
    wr(8'h08, 32'd5);
    begin
      int early = 0;
      for (int n = 0; n < 40 && !pwm_o[1]; n++) begin
        early += int'(pwm_o[0]);
        @(negedge clk);
      end
      chk("R9 no change before wrap", early, 0);
      chk("R9 marker seen", {31'd0, pwm_o[1]}, 1);
      chk("R9 applied at wrap", {31'd0, pwm_o[0]}, 1);
    end

    // R4 R6 R7 R8 random configurations
    for (int t = 0; t < 40; t++) begin
      int per;
      logic [11:0] ctl;
      per = 1 + int'($urandom_range(39));
      ctl = 12'($urandom);
      for (int c = 0; c < 4; c++) duty[c] = int'($urandom_range(50));
      if (t == 0) begin duty[0] = 0; duty[1] = per; duty[2] = per - 1; duty[3] = per + 1; end
      wr(8'h00, {20'd0, ctl});
      wr(8'h04, per);
      for (int c = 0; c < 4; c++) wr(8'(8 + 4*c), duty[c]);
      wait_cycles(100);
      measure(per);
      for (int c = 0; c < 4; c++) chk("R4 high count", hi[c], exp_hi(ctl, c, per, duty[c]));
      chk("R8 dir", {28'd0, dir_o}, {28'd0, ctl[7:4]});
      chk("R6 brake", {28'd0, brake_o}, {28'd0, ctl[11:8]});
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule